// File: doc/BRIEF.md
# Dual-Rate Peripheral Clock-Enable Generator

This block turns one oscillator clock into single-cycle enable pulses for a CPU and seven peripherals. A global speed-up bit sets the CPU machine cycle to 12 or 6 oscillator periods. While that bit is set, each peripheral has its own bit that picks 6 or 12 periods. While it is clear, everything runs at 12 periods and the peripheral bits are ignored.

An 8-bit control byte holds the settings. It is written and read back as a whole byte. At reset the global bit is preset from a configuration input, and every peripheral bit is cleared.

A shared phase counter defines a 12-period frame. Every pulse falls either at the start of a frame or at its midpoint. A rate change is committed only at a frame start, so no output ever produces a shortened or stretched cycle. The UART enable is meant for that peripheral's synchronous and fixed-rate modes only.

Top module: `clk_rate_gen`

## Requirements
- R1: While reset is held, and afterwards until the first write, `rdData` reads `{7'b0, bootFast}`. Bit 0 of the byte is the global speed-up bit.
- R2: A byte presented with `wrEn` high is stored at that clock edge, and `rdData` shows it from the next cycle on. There is no write to a single bit.
- R3: With global bit 0, `cpuTick` and every `periphTick` bit pulse once every 12 clocks, whatever the value of bits 7..1.
- R4: With global bit 1, `cpuTick` pulses once every 6 clocks.
- R5: With global bit 1, `periphTick[i]` is controlled by byte bit i+1: 0 gives a pulse every 6 clocks and 1 gives a pulse every 12 clocks. The bits map as follows:
  - `periphTick[0]` timer 0
  - `periphTick[1]` timer 1
  - `periphTick[2]` timer 2
  - `periphTick[3]` UART
  - `periphTick[4]` counter array
  - `periphTick[5]` watchdog
  - `periphTick[6]` two-wire serial
- R6: Every enable pulse lasts exactly one clock cycle.
- R7: Pulses occur only at frame start (phase 0) or at frame midpoint (phase 6). A 12-period pulse therefore always coincides with a pulse of every 6-period output, and no peripheral pulses without `cpuTick`.
- R8: A rate change written during a frame takes effect at the next frame start. If several writes land in one frame, only the last one counts. The spacing between consecutive pulses of any output is always 6 or 12.
- R9: In the first cycle after reset is released, every output pulses. That cycle is phase 0 of the first frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bootFast | input | 1 | Reset preset for the global speed-up bit |
| wrEn | input | 1 | Byte write strobe for the control byte |
| wrData | input | 8 | Control byte to write |
| rdData | output | 8 | Current control byte |
| cpuTick | output | 1 | CPU machine-cycle enable |
| periphTick | output | 7 | Peripheral enables, mapped as in R5 |

## Verification
The bench aims at the following corner cases:

- **Peripheral bits set while the global bit is clear.** A design that honoured those bits there would give 6-period pulses where R3 requires 12.
- **Rate changes at assorted offsets inside a frame, including two writes in one frame.** A design that switched at once would produce 6-after-12 gaps or off-phase pulses. One that kept the first of two writes would run at the wrong rate for a whole frame.
- **Reset with the preset both low and high.** A wrong reset value shows up in the read-back. A phase counter not starting at zero shows up as a missing first pulse.
- **The bit-to-peripheral mapping, tested with asymmetric patterns.** A reversed or shifted mapping shows up on specific `periphTick` bits.

// File: rtl/clk_rate_pkg.sv
package clk_rate_pkg;
  localparam int NUM_PERIPH = 7;
  localparam int CFG_W      = NUM_PERIPH + 1;

  typedef struct packed {
    logic             frameLoad;
    logic             fullTick;
    logic             halfTick;
    logic [CFG_W-1:0] reqFast;
  } rate_strobe_t;
endpackage

// File: rtl/clk_rate_ctrl.sv
module clk_rate_ctrl
  import clk_rate_pkg::*;
#(
  parameter int SLOW_DIV = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bootFast,
  input  logic             wrEn,
  input  logic [CFG_W-1:0] wrData,
  output logic [CFG_W-1:0] cfgQ,
  output rate_strobe_t     strb
);
  localparam int HALF_DIV = SLOW_DIV / 2;
  localparam int PH_W     = $clog2(SLOW_DIV);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(SLOW_DIV - 1);
  localparam logic [PH_W-1:0] PH_HALF = PH_W'(HALF_DIV);

  logic [PH_W-1:0] phase;

  // control byte, global bit preset from the configuration input
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgQ <= {{NUM_PERIPH{1'b0}}, bootFast};
    else if (wrEn) cfgQ <= wrData;
  end

  // frame phase counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= '0;
    else if (phase == PH_LAST) phase <= '0;
    else phase <= phase + 1'b1;
  end

  // effective fast request: CPU follows global bit, peripherals gated by it
  assign strb.reqFast[0] = cfgQ[0];
  for (genvar i = 1; i < CFG_W; i++) begin : g_req
    assign strb.reqFast[i] = cfgQ[0] & ~cfgQ[i];
  end

  assign strb.frameLoad = rstN && (phase == PH_LAST);
  assign strb.fullTick  = rstN && (phase == '0);
  assign strb.halfTick  = rstN && ((phase == '0) || (phase == PH_HALF));
endmodule

// File: rtl/clk_rate_dp.sv
module clk_rate_dp
  import clk_rate_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             bootFast,
  input  rate_strobe_t     strb,
  output logic [CFG_W-1:0] ticks
);
  logic [CFG_W-1:0] activeFast;

  for (genvar i = 0; i < CFG_W; i++) begin : g_out
    // committed rate, swapped only at frame boundary
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) activeFast[i] <= bootFast;
      else if (strb.frameLoad) activeFast[i] <= strb.reqFast[i];
    end
    assign ticks[i] = strb.fullTick | (strb.halfTick & activeFast[i]);
  end
endmodule

// File: rtl/clk_rate_gen.sv
module clk_rate_gen
  import clk_rate_pkg::*;
#(
  parameter int SLOW_DIV = 12
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  bootFast,
  input  logic                  wrEn,
  input  logic [CFG_W-1:0]      wrData,
  output logic [CFG_W-1:0]      rdData,
  output logic                  cpuTick,
  output logic [NUM_PERIPH-1:0] periphTick
);
  rate_strobe_t     strb;
  logic [CFG_W-1:0] ticks;

  clk_rate_ctrl #(.SLOW_DIV(SLOW_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .bootFast(bootFast), .wrEn(wrEn),
    .wrData(wrData), .cfgQ(rdData), .strb(strb)
  );

  clk_rate_dp u_dp (
    .clk(clk), .rstN(rstN), .bootFast(bootFast), .strb(strb), .ticks(ticks)
  );

  assign cpuTick    = ticks[0];
  assign periphTick = ticks[CFG_W-1:1];
endmodule

// File: rtl/clk_rate_chk.sv
module clk_rate_chk
  import clk_rate_pkg::*;
#(
  parameter int SLOW_DIV = 12
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  wrEn,
  input logic [CFG_W-1:0]      wrData,
  input logic [CFG_W-1:0]      rdData,
  input logic                  cpuTick,
  input logic [NUM_PERIPH-1:0] periphTick
);
  localparam int GAP_W = $clog2(SLOW_DIV) + 2;
  logic [CFG_W-1:0] allTicks;
  logic primed;
  assign allTicks = {periphTick, cpuTick};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) primed <= 1'b0;
    else primed <= 1'b1;
  end

  // R2
  wr_visible_chk: assert property (@(posedge clk) disable iff (!rstN)
    primed && $past(wrEn) |-> rdData == $past(wrData));

  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    primed && (|$past(allTicks)) |-> (($past(allTicks) & allTicks) == '0));

  // R7
  align_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|periphTick) |-> cpuTick);

  for (genvar i = 0; i < CFG_W; i++) begin : g_gap
    logic [GAP_W-1:0] gap;
    logic seen;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        gap <= '0;
        seen <= 1'b0;
      end else if (allTicks[i]) begin
        gap <= GAP_W'(1);
        seen <= 1'b1;
      end else if (gap != '1) begin
        gap <= gap + 1'b1;
      end
    end
    // R8
    spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
      allTicks[i] && seen |-> (gap == GAP_W'(SLOW_DIV) || gap == GAP_W'(SLOW_DIV / 2)));
  end
endmodule

bind clk_rate_gen clk_rate_chk #(.SLOW_DIV(SLOW_DIV)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
  .cpuTick(cpuTick), .periphTick(periphTick)
);

// File: tb/tb_clk_rate_gen.sv
`timescale 1ns/1ps
module tb_clk_rate_gen;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bootFast = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic cpuTick;
  logic [6:0] periphTick;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  string curTag = "R3";
  bit done = 0;

  typedef struct { int vis; logic [7:0] val; } item_t;
  item_t pendQ[$];
  logic [7:0] model = '0;

  always #2 clk = ~clk;

  clk_rate_gen dut (
    .clk(clk), .rstN(rstN), .bootFast(bootFast), .wrEn(wrEn),
    .wrData(wrData), .rdData(rdData), .cpuTick(cpuTick), .periphTick(periphTick)
  );

  // monitor: reference frame model, compares every cycle
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (!rstN) begin
        cyc = 0;
        model = {7'b0, bootFast};
        pendQ.delete();
      end else begin
        logic [7:0] expT;
        int ph;
        ph = cyc % 12;
        if (ph == 0) begin
          while (pendQ.size() > 0 && pendQ[0].vis <= cyc - 1) begin
            model = pendQ[0].val;
            void'(pendQ.pop_front());
          end
        end
        expT[0] = (ph == 0) || (model[0] && ph == 6);
        for (int i = 1; i < 8; i++)
          expT[i] = (ph == 0) || (model[0] && !model[i] && ph == 6);
        total++;
        if ({periphTick, cpuTick} !== expT) begin
          bad++;
          $display("FAIL %s/R6/R7 cycle %0d: got %b expected %b",
                   (cyc < 12) ? "R9" : curTag, cyc, {periphTick, cpuTick}, expT);
        end
        cyc++;
      end
    end
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // driver: one byte write, pushes expected item, checks read-back (R2)
  task automatic writeReg(input logic [7:0] v);
    @(negedge clk);
    wrEn = 1'b1;
    wrData = v;
    pendQ.push_back('{vis: cyc + 1, val: v});
    @(negedge clk);
    wrEn = 1'b0;
    #1;
    check("R2", rdData, v);
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset(input logic boot);
    @(negedge clk);
    rstN = 1'b0;
    bootFast = boot;
    #1;
    check("R1 during reset", rdData, {7'b0, boot});
    waitCycles(3);
    rstN = 1'b1;
    #1;
    check("R1 after release", rdData, {7'b0, boot});
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    total++;
    $display("FAIL watchdog: got timeout expected completion");
    finishRun();
  end

  initial begin
    doReset(1'b0);
    curTag = "R3";
    waitCycles(48);
    writeReg(8'hFE);       // R3: peripheral bits ignored with global clear
    waitCycles(48);
    curTag = "R4";
    writeReg(8'h01);       // R4/R5: all fast
    waitCycles(48);
    curTag = "R5";
    writeReg(8'hFF);       // R5: CPU fast, all peripherals slow
    waitCycles(48);
    writeReg(8'h55);       // R5: mixed pattern
    waitCycles(36);
    writeReg(8'hA3);       // R5: asymmetric mapping
    waitCycles(36);
    curTag = "R8";
    for (int k = 0; k < 12; k++) begin
      waitCycles(k);       // R8: changes at varying offsets in a frame
      writeReg((k % 2) ? 8'h01 : 8'h00);
      waitCycles(17);
    end
    waitCycles(5);
    writeReg(8'h01);       // R8: two writes inside one frame, last wins
    writeReg(8'hFD);
    waitCycles(30);
    writeReg(8'h00);
    waitCycles(30);
    doReset(1'b1);         // R1/R9 with preset high
    curTag = "R4";
    waitCycles(36);
    curTag = "R5";
    writeReg(8'h81);
    waitCycles(36);
    curTag = "R3";
    writeReg(8'h80);
    waitCycles(36);
    finishRun();
  end
endmodule